// File: doc/BRIEF.md
# Boot-Time Configuration Capture and Memory Block Decoder

This block sits at the front of a burst-mode DRAM controller. After its reset input is released, it watches the processor bus for the first accepted 32-bit data read. It takes the word on the read data bus during that access as its setup word and does not treat the access as a memory cycle. From that word it holds the byte-numbering convention, the row-strobe length, the burst-write speed, the refresh divisor, the DRAM size code and the base address of the memory block it serves.

Once set up, the block checks every request that the bus qualifies against the configured block. It raises a select flag and a four-lane byte enable one cycle after the request. The block's size follows from the DRAM size code, and the block always starts on a boundary equal to its size. Only the address bits above the block size are compared with the programmed base.

A reset-out pin stays low until setup has finished. Several controllers can therefore be chained, each one releasing the next controller's reset once its own setup is done.

Top module: `boot_cfg_decoder`

## Requirements
- R1: While `rst_n` is sampled low, and on the first cycle after it, `chain_rst_n` is 0, `sel_o` is 0, `be_o` is 0 and every exported setup field is 0.
- R2: The first data read after reset that is qualified (see R6), has `opt_i` = 0 (word) and has `wr_i` = 0 latches `rdata_i` at that clock edge. From the next cycle `chain_rst_n` is 1. Later reads leave the setup fields unchanged until the next reset.
- R3: A data write, or a data read with `opt_i` other than 0, does not latch setup and leaves `chain_rst_n` at 0.
- R4: `sel_o` stays 0 until setup has been latched, whatever the address.
- R5: Setup bits 7:6 give the size code: 0 is 512 KB, 1 is 2 MB, 2 is 8 MB and 3 is 32 MB. A request hits only when address bits 31 down to log2(block size) equal the same bits of the setup word. Lower address bits are ignored.
- R6: A data request (`dreq_i` = 1) is accepted only when `bus_inval_i` = 0, `dtype_i` = 2'b00 and `opt_i` is 0 (word), 1 (halfword) or 2 (byte).
- R7: An instruction request (`ireq_i` = 1) is accepted only when `bus_inval_i` = 0 and `itype_i` = 0. A hit enables all four lanes.
- R8: With setup bit 16 = 0, byte address k (`addr_i[1:0]`) enables lane k, where lane k is data bits 8k+7:8k. A halfword enables lanes 1:0 when `addr_i[1]` = 0 and lanes 3:2 otherwise. A word enables all lanes. `be_o` is 0 whenever `sel_o` is 0.
- R9: With setup bit 16 = 1, byte address k enables lane 3-k. A halfword at `addr_i[1]` = 0 enables lanes 3:2, and at `addr_i[1]` = 1 it enables lanes 1:0.
- R10: `cfg_big_o` is setup bit 16, `cfg_ras3_o` is bit 17 (1 means a 3-cycle row strobe) and `cfg_wr1_o` is bit 18 (1 means single-clock burst writes). `cfg_refdiv_o` is bits 13:8 and `cfg_size_o` is bits 7:6.
- R11: Crossing a word boundary is not detected: a halfword ignores `addr_i[0]`.
- R12: The block base is setup bits 31:19, aligned with address bits 31:19.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset; the previous controller's chain output |
| dreq_i | input | 1 | Data request strobe |
| ireq_i | input | 1 | Instruction request strobe |
| bus_inval_i | input | 1 | Address and controls invalid when 1 |
| dtype_i | input | 2 | Data address-space type; 00 is accepted |
| itype_i | input | 1 | Instruction address-space type; 0 is accepted |
| wr_i | input | 1 | 1 for a write, 0 for a read |
| opt_i | input | 3 | Access size: 0 word, 1 halfword, 2 byte |
| addr_i | input | 32 | Byte address |
| rdata_i | input | 32 | Read data bus, used only for setup capture |
| chain_rst_n | output | 1 | Reset for the next controller; low until setup is latched |
| sel_o | output | 1 | Registered block select |
| be_o | output | 4 | Registered byte-lane enables |
| cfg_big_o | output | 1 | Reversed byte numbering |
| cfg_ras3_o | output | 1 | 3-cycle row strobe when 1 |
| cfg_wr1_o | output | 1 | Single-clock burst write when 1 |
| cfg_refdiv_o | output | 6 | Refresh divisor field |
| cfg_size_o | output | 2 | DRAM size code |

## Verification
Every result here sits one register away from the bus. The setup fields and `chain_rst_n` change at the clock edge that samples the capturing read. `sel_o` and `be_o` change at the edge that samples the request. The bench therefore drives each request on a falling edge, lets one rising edge pass, and compares all outputs on the next falling edge. Rejected and ignored stimuli are checked the same way: through `sel_o`, `be_o`, `chain_rst_n` and the exported fields, one cycle after the stimulus and before the next one.

// File: rtl/bcd_pkg.sv
// Shared widths, field positions and types for the setup decoder.
// Assumes a 32-bit data word split into four byte lanes.
package bcd_pkg;
    localparam int ADDR_W      = 32;
    localparam int DATA_W      = 32;
    localparam int LANES       = DATA_W / 8;
    localparam int MIN_BLK_LG  = 19;                 // 512 KB smallest block
    localparam int BASE_W      = ADDR_W - MIN_BLK_LG;
    localparam int REF_W       = 6;

    localparam int POS_SIZE    = 6;
    localparam int POS_REF     = 8;
    localparam int POS_BIG     = 16;
    localparam int POS_RAS3    = 17;
    localparam int POS_WR1     = 18;

    typedef enum logic [2:0] {
        SZ_WORD = 3'd0,
        SZ_HALF = 3'd1,
        SZ_BYTE = 3'd2
    } acc_size_e;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic              wr1;
        logic              ras3;
        logic              big;
        logic [REF_W-1:0]  refdiv;
        logic [1:0]        size;
    } cfg_t;
endpackage

// File: rtl/bcd_qualify.sv
// Request qualification: decides whether a data or instruction request
// is accepted and whether it is the setup-capturing word read.
// Assumes active-high request strobes and the size codes in bcd_pkg.
module bcd_qualify
    import bcd_pkg::*;
(
    input  logic       dreq_i,
    input  logic       ireq_i,
    input  logic       bus_inval_i,
    input  logic [1:0] dtype_i,
    input  logic       itype_i,
    input  logic       wr_i,
    input  logic [2:0] opt_i,
    input  logic       cfg_done_i,
    output logic       d_ok_o,
    output logic       i_ok_o,
    output logic       cap_o
);
    logic size_ok;

    // Purpose: only word, halfword and byte transfers are served.
    always_comb begin
        size_ok = (opt_i == SZ_WORD) || (opt_i == SZ_HALF) || (opt_i == SZ_BYTE);
    end

    // Purpose: accept requests and flag the setup read.
    always_comb begin
        d_ok_o = dreq_i && !bus_inval_i && (dtype_i == 2'b00) && size_ok;
        i_ok_o = !d_ok_o && ireq_i && !bus_inval_i && !itype_i;
        cap_o  = d_ok_o && !wr_i && (opt_i == SZ_WORD) && !cfg_done_i;
    end
endmodule

// File: rtl/bcd_capture.sv
// Setup capture: latches the first word read after reset and splits it
// into fields. Assumes the word is valid on rdata_i at the accepting edge.
module bcd_capture
    import bcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              done_o,
    output cfg_t              cfg_o
);
    logic [DATA_W-1:0] word_q;
    logic              done_q;

    // Purpose: hold the setup word once, until the next reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            done_q <= 1'b0;
        end else if (cap_i && !done_q) begin
            word_q <= rdata_i;
            done_q <= 1'b1;
        end
    end

    // Purpose: map word bits to the named fields.
    always_comb begin
        cfg_o.base   = word_q[DATA_W-1:MIN_BLK_LG];
        cfg_o.wr1    = word_q[POS_WR1];
        cfg_o.ras3   = word_q[POS_RAS3];
        cfg_o.big    = word_q[POS_BIG];
        cfg_o.refdiv = word_q[POS_REF +: REF_W];
        cfg_o.size   = word_q[POS_SIZE +: 2];
        done_o       = done_q;
    end

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> done_q);                                   // R2
    AST_WORD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> $stable(word_q));                          // R2
endmodule

// File: rtl/bcd_match.sv
// Block match: compares the address bits above the block size with the
// programmed base. Each step of the size code adds two ignored bits.
module bcd_match
    import bcd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BASE_W-1:0] base_i,
    input  logic [1:0]        size_i,
    output logic              hit_o
);
    logic [BASE_W-1:0] bit_ok;

    genvar g;
    generate
        for (g = 0; g < BASE_W; g++) begin : g_bit
            // Purpose: a bit counts only when it lies above the block size.
            always_comb begin
                bit_ok[g] = (g < 2 * int'(size_i)) ||
                            (addr_i[MIN_BLK_LG + g] == base_i[g]);
            end
        end
    endgenerate

    // Purpose: reduce the per-bit results to one hit.
    always_comb begin
        hit_o = &bit_ok;
    end
endmodule

// File: rtl/bcd_lanes.sv
// Byte-lane decode for word, halfword and byte transfers under either
// byte numbering. Assumes misaligned halfwords are software's concern.
module bcd_lanes
    import bcd_pkg::*;
(
    input  logic [1:0]       low_i,
    input  logic [2:0]       opt_i,
    input  logic             big_i,
    input  logic             instr_i,
    output logic [LANES-1:0] be_o
);
    logic [LANES-1:0] le;

    // Purpose: lane pattern for little-endian numbering.
    always_comb begin
        le = '0;
        if (instr_i || opt_i == SZ_WORD) begin
            le = '1;
        end else if (opt_i == SZ_HALF) begin
            le = low_i[1] ? 4'b1100 : 4'b0011;
        end else begin
            le[low_i] = 1'b1;
        end
    end

    genvar l;
    generate
        for (l = 0; l < LANES; l++) begin : g_lane
            // Purpose: mirror lanes when numbering is reversed.
            always_comb begin
                be_o[l] = big_i ? le[LANES-1-l] : le[l];
            end
        end
    endgenerate
endmodule

// File: rtl/boot_cfg_decoder.sv
// Top: captures setup after reset, exports its fields, drives the chain
// reset and registers block select and lane enables one cycle after a
// request. Assumes requests last one cycle as seen by this block.
module boot_cfg_decoder
    import bcd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dreq_i,
    input  logic        ireq_i,
    input  logic        bus_inval_i,
    input  logic [1:0]  dtype_i,
    input  logic        itype_i,
    input  logic        wr_i,
    input  logic [2:0]  opt_i,
    input  logic [31:0] addr_i,
    input  logic [31:0] rdata_i,
    output logic        chain_rst_n,
    output logic        sel_o,
    output logic [3:0]  be_o,
    output logic        cfg_big_o,
    output logic        cfg_ras3_o,
    output logic        cfg_wr1_o,
    output logic [5:0]  cfg_refdiv_o,
    output logic [1:0]  cfg_size_o
);
    logic             d_ok, i_ok, cap, done, hit;
    cfg_t             cfg;
    logic [LANES-1:0] lanes;
    logic             sel_q;
    logic [LANES-1:0] be_q;

    bcd_qualify u_qual (
        .dreq_i(dreq_i), .ireq_i(ireq_i), .bus_inval_i(bus_inval_i),
        .dtype_i(dtype_i), .itype_i(itype_i), .wr_i(wr_i), .opt_i(opt_i),
        .cfg_done_i(done), .d_ok_o(d_ok), .i_ok_o(i_ok), .cap_o(cap)
    );

    bcd_capture u_cap (
        .clk(clk), .rst_n(rst_n), .cap_i(cap), .rdata_i(rdata_i),
        .done_o(done), .cfg_o(cfg)
    );

    bcd_match u_match (
        .addr_i(addr_i), .base_i(cfg.base), .size_i(cfg.size), .hit_o(hit)
    );

    bcd_lanes u_lanes (
        .low_i(addr_i[1:0]), .opt_i(opt_i), .big_i(cfg.big),
        .instr_i(i_ok), .be_o(lanes)
    );

    // Purpose: register select and lanes one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
            be_q  <= '0;
        end else if (done && (d_ok || i_ok) && hit) begin
            sel_q <= 1'b1;
            be_q  <= lanes;
        end else begin
            sel_q <= 1'b0;
            be_q  <= '0;
        end
    end

    // Purpose: drive outputs from held state.
    always_comb begin
        chain_rst_n  = done;
        sel_o        = sel_q;
        be_o         = be_q;
        cfg_big_o    = cfg.big;
        cfg_ras3_o   = cfg.ras3;
        cfg_wr1_o    = cfg.wr1;
        cfg_refdiv_o = cfg.refdiv;
        cfg_size_o   = cfg.size;
    end

    AST_NO_SEL_UNCFG: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> !sel_q);                                    // R4
    AST_LANES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_q |-> (be_q == '0));                             // R8
    AST_LANES_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q |-> ($countones(be_q) == 1 || $countones(be_q) == 2 ||
                   $countones(be_q) == 4));                   // R8
    AST_CHAIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        chain_rst_n |=> chain_rst_n);                         // R2
endmodule

// File: tb/tb_boot_cfg_decoder.sv
module tb_boot_cfg_decoder;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        dreq_i, ireq_i, bus_inval_i, itype_i, wr_i;
    logic [1:0]  dtype_i;
    logic [2:0]  opt_i;
    logic [31:0] addr_i, rdata_i;
    logic        chain_rst_n, sel_o;
    logic [3:0]  be_o;
    logic        cfg_big_o, cfg_ras3_o, cfg_wr1_o;
    logic [5:0]  cfg_refdiv_o;
    logic [1:0]  cfg_size_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    boot_cfg_decoder dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        dreq_i = 0; ireq_i = 0; bus_inval_i = 0; itype_i = 0; wr_i = 0;
        dtype_i = 0; opt_i = 0; addr_i = 0; rdata_i = 0;
    endtask

    // One bus cycle driven on a falling edge, results sampled one cycle later.
    task automatic bus(input logic d, input logic i, input logic inv,
                       input logic [1:0] dt, input logic it, input logic w,
                       input logic [2:0] op, input logic [31:0] a,
                       input logic [31:0] rd);
        @(negedge clk);
        dreq_i = d; ireq_i = i; bus_inval_i = inv; dtype_i = dt;
        itype_i = it; wr_i = w; opt_i = op; addr_i = a; rdata_i = rd;
        @(negedge clk);
        idle();
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle();
        rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 chain", chain_rst_n, 0);
        chk("R1 sel", sel_o, 0);
        chk("R1 be", be_o, 0);
        chk("R1 fields", {cfg_big_o, cfg_ras3_o, cfg_wr1_o, cfg_refdiv_o, cfg_size_o}, 0);
    endtask

    task automatic t_no_capture();
        bus(1, 0, 0, 0, 0, 0, 1, 32'h0, 32'hFFFF_FFFF);
        chk("R3 halfword read not captured", chain_rst_n, 0);
        bus(1, 0, 0, 0, 0, 1, 0, 32'h0, 32'hFFFF_FFFF);
        chk("R3 write not captured", chain_rst_n, 0);
        chk("R3 fields untouched", {cfg_ras3_o, cfg_refdiv_o}, 0);
        bus(1, 0, 0, 0, 0, 0, 1, 32'h0, 32'h0);
        chk("R4 no select before setup", sel_o, 0);
    endtask

    task automatic t_config_small();
        // base 0x0060_0000, size 1 (2 MB), ras3=1, wr1=0, little, refdiv 0x2A
        bus(1, 0, 0, 0, 0, 0, 0, 32'h0, 32'h0060_0000 | (1 << 17) | (32'h2A << 8) | (1 << 6));
        chk("R2 chain released", chain_rst_n, 1);
        chk("R2 setup read not selected", sel_o, 0);
        chk("R10 ras3", cfg_ras3_o, 1);
        chk("R10 wr1", cfg_wr1_o, 0);
        chk("R10 big", cfg_big_o, 0);
        chk("R10 refdiv", cfg_refdiv_o, 6'h2A);
        chk("R10 size", cfg_size_o, 2'd1);
        bus(1, 0, 0, 0, 0, 0, 0, 32'h0, 32'hFFFF_FFFF);
        chk("R2 second read ignored", {cfg_big_o, cfg_ras3_o, cfg_wr1_o, cfg_refdiv_o, cfg_size_o},
            {1'b0, 1'b1, 1'b0, 6'h2A, 2'd1});
    endtask

    task automatic t_match_small();
        bus(1, 0, 0, 0, 0, 0, 0, 32'h0060_0000, 0);
        chk("R12 base hit", sel_o, 1);
        chk("R8 word lanes", be_o, 4'b1111);
        bus(1, 0, 0, 0, 0, 0, 0, 32'h007F_FFFC, 0);
        chk("R5 top of 2MB block hit", sel_o, 1);
        bus(1, 0, 0, 0, 0, 0, 0, 32'h0068_0000, 0);
        chk("R5 bit19 ignored for 2MB", sel_o, 1);
        bus(1, 0, 0, 0, 0, 0, 0, 32'h0080_0000, 0);
        chk("R5 next block miss", sel_o, 0);
        chk("R8 lanes zero on miss", be_o, 0);
        bus(1, 0, 0, 0, 0, 0, 0, 32'h8060_0000, 0);
        chk("R12 high bit compared", sel_o, 0);
    endtask

    task automatic t_lanes_little();
        for (int k = 0; k < 4; k++) begin
            bus(1, 0, 0, 0, 0, 0, 2, 32'h0060_0000 + k, 0);
            chk("R8 byte lane", be_o, 4'b0001 << k);
        end
        bus(1, 0, 0, 0, 0, 0, 1, 32'h0060_0000, 0);
        chk("R8 half low", be_o, 4'b0011);
        bus(1, 0, 0, 0, 0, 0, 1, 32'h0060_0002, 0);
        chk("R8 half high", be_o, 4'b1100);
        bus(1, 0, 0, 0, 0, 0, 1, 32'h0060_0003, 0);
        chk("R11 odd half not split", be_o, 4'b1100);
    endtask

    task automatic t_accept();
        bus(1, 0, 1, 0, 0, 0, 0, 32'h0060_0000, 0);
        chk("R6 bus invalid rejects", sel_o, 0);
        bus(1, 0, 0, 2'b01, 0, 0, 0, 32'h0060_0000, 0);
        chk("R6 dtype rejects", sel_o, 0);
        bus(1, 0, 0, 2'b10, 0, 0, 0, 32'h0060_0000, 0);
        chk("R6 dtype high rejects", sel_o, 0);
        bus(1, 0, 0, 0, 0, 0, 3, 32'h0060_0000, 0);
        chk("R6 size code 3 rejects", sel_o, 0);
        bus(1, 0, 0, 0, 0, 1, 0, 32'h0060_0000, 0);
        chk("R6 write accepted", sel_o, 1);
        bus(0, 1, 0, 0, 1, 0, 0, 32'h0060_0000, 0);
        chk("R7 itype rejects", sel_o, 0);
        bus(0, 1, 1, 0, 0, 0, 0, 32'h0060_0000, 0);
        chk("R7 bus invalid rejects", sel_o, 0);
        bus(0, 1, 0, 0, 0, 0, 2, 32'h0060_0001, 0);
        chk("R7 instruction hit", sel_o, 1);
        chk("R7 instruction lanes", be_o, 4'b1111);
    endtask

    task automatic t_config_big();
        do_reset();
        chk("R1 chain after re-reset", chain_rst_n, 0);
        // base 0x0A00_0000, size 3 (32 MB), big, wr1=1, ras3=0, refdiv 0x3F
        bus(1, 0, 0, 0, 0, 0, 0, 32'h0, 32'h0A00_0000 | (1 << 18) | (1 << 16) | (32'h3F << 8) | (3 << 6));
        chk("R10 wr1", cfg_wr1_o, 1);
        chk("R10 ras3 low", cfg_ras3_o, 0);
        chk("R10 big", cfg_big_o, 1);
        chk("R10 refdiv", cfg_refdiv_o, 6'h3F);
        chk("R10 size", cfg_size_o, 2'd3);
        for (int k = 0; k < 4; k++) begin
            bus(1, 0, 0, 0, 0, 0, 2, 32'h0A00_0000 + k, 0);
            chk("R9 byte lane", be_o, 4'b1000 >> k);
        end
        bus(1, 0, 0, 0, 0, 0, 1, 32'h0A00_0000, 0);
        chk("R9 half low", be_o, 4'b1100);
        bus(1, 0, 0, 0, 0, 0, 1, 32'h0A00_0002, 0);
        chk("R9 half high", be_o, 4'b0011);
        bus(1, 0, 0, 0, 0, 0, 0, 32'h0BFF_FFFC, 0);
        chk("R5 32MB top hit", sel_o, 1);
        bus(1, 0, 0, 0, 0, 0, 0, 32'h0C00_0000, 0);
        chk("R5 32MB next miss", sel_o, 0);
        bus(1, 0, 0, 0, 0, 0, 0, 32'h0800_0000, 0);
        chk("R5 32MB below miss", sel_o, 0);
    endtask

    initial begin
        fork
            begin
                idle();
                rst_n = 0;
                t_reset();
                t_no_capture();
                t_config_small();
                t_match_small();
                t_lanes_little();
                t_accept();
                t_config_big();
            end
            begin
                repeat (200000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule